// File: doc/BRIEF.md
# NAND Bus Strobe Timing Sequencer

This block turns single register-side requests into timed cycles on the pins of an asynchronous NAND flash device. Each request is a command write, an address write, a data write or a data read, together with one data byte. The block asserts chip enable and waits a chip-enable-to-access delay. A command write then raises CLE and an address write raises ALE. A write pulses WE low and then high, and a read pulses RE low and then high. Read data is returned on a response stream. All phase lengths are counted in system clocks and are taken from one packed timing word, which is sampled when a request is accepted.

Requests arrive on a valid/ready stream. `req_ready` is high only while the sequencer is idle, and a request that is offered while a cycle runs stays pending until it is accepted. Read results leave on a valid/ready stream. The sequencer holds `rsp_valid` and `rsp_data` steady and takes no new request until `rsp_ready` accepts the byte. After a write the data bus stays driven. A later read first releases the bus for a turnaround gap. After a command or data write, the device's ready/busy pin is masked for a programmable number of clocks before the device can be reported ready.

Top module: `nand_strobe_seq`

## Requirements
- R1: During and right after reset: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_dq_oe` and `rsp_valid` are low, and `req_ready` and `stat_ctrl_idle` are high.
- R2: `req_ready` and `stat_ctrl_idle` are high only when the sequencer is idle. The sequencer takes a request on a clock where `req_valid` and `req_ready` are both high. A request held while a cycle or an unaccepted response is pending is not started, and no CLE, ALE or strobe appears for it until it is accepted.
- R3: Op code 0 is a command write. It drives `req_data` on `nand_dq_o` with CLE high and ALE low while WE is low. The byte 0xFF is sent as an ordinary command cycle.
- R4: Op code 1 is an address write. It drives the byte with ALE high and CLE low while WE is low.
- R5: Op code 2 is a data write. It drives the byte with `nand_dq_oe` high and with both CLE and ALE low.
- R6: The timing word fields are: write-low [3:0], write-high [7:4], read-low [11:8], read-high [15:12], turnaround [18:16], busy delay [23:19] and chip-enable-to-access delay [25:24]. A write keeps the sequencer busy for CE-delay + write-low + write-high clocks, with WE low for exactly write-low clocks.
- R7: A CE-delay, strobe or turnaround field of zero lasts one clock.
- R8: Op code 3 is a data read. RE is low for read-low clocks and then high for read-high clocks. `nand_dq_i` is sampled on the clock where RE rises and is returned with `rsp_valid`. Under back-pressure, `rsp_valid` and `rsp_data` stay unchanged until `rsp_ready` is high.
- R9: After a write, `nand_dq_oe` stays high while the sequencer is idle. A read that follows a write drops `nand_dq_oe` and waits for the turnaround count before RE falls. A read that follows a read has no gap. RE is never low while `nand_dq_oe` is high.
- R10: After a command or data write, `stat_nand_ready` stays low for busy-delay clocks from the return to idle, whatever the level of `nand_rb_n`. An address write starts no busy delay.
- R11: Outside the busy delay, `stat_nand_ready` follows `nand_rb_n` (high = ready) through a two-stage synchronizer.
- R12: `nand_ce_n` goes low in the clock after acceptance, and WE and RE stay high for the CE-delay clocks. `nand_ce_n` returns high once the strobe-high phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 26 | Packed phase lengths, sampled on acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | DATA_W | Byte sampled from the device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | DATA_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DATA_W | Data bus input value |
| nand_rb_n | input | 1 | Device ready/busy, high when ready |
| stat_nand_ready | output | 1 | Device ready and busy delay elapsed |
| stat_ctrl_idle | output | 1 | Sequencer idle |

## Verification
The bench builds the block with the default `DATA_W` of 8. It changes the timing word between operations, using an all-zero word, a mixed word and a word with every field at its maximum. The all-zero word reaches the one-clock floor of every phase. The maximum word reaches fifteen-clock strobes, a seven-clock turnaround and a thirty-one-clock busy mask, all within a short run. It orders reads after writes and after reads to reach both turnaround paths, and it withholds `rsp_ready` while a second request waits.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  // Width of the packed timing word and of the phase counters.
  localparam int TW_W = 26;
  localparam int PH_W = 5;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } nand_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CE,
    ST_TURN,
    ST_LOW,
    ST_HIGH,
    ST_RESP
  } seq_state_e;

  // Full timing word, MSB first; field positions are the register layout.
  typedef struct packed {
    logic [1:0] ce_dly;
    logic [4:0] busy_dly;
    logic [2:0] turn;
    logic [3:0] rd_high;
    logic [3:0] rd_low;
    logic [3:0] wr_high;
    logic [3:0] wr_low;
  } timing_t;

  // Fields still needed after the chip-enable phase has been loaded.
  typedef struct packed {
    logic [4:0] busy_dly;
    logic [2:0] turn;
    logic [3:0] rd_high;
    logic [3:0] rd_low;
    logic [3:0] wr_high;
    logic [3:0] wr_low;
  } strobe_cfg_t;

endpackage

// File: rtl/nand_phase_timer.sv
`timescale 1ns/1ps
module nand_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  // A length of zero or one both give a one-clock phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_len == '0) ? '0 : load_len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R7
  short_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_len <= 1) |=> done);

  // R6
  long_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_len > 1) |=> !done);

endmodule

// File: rtl/nand_busy_guard.sv
`timescale 1ns/1ps
module nand_busy_guard #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             rb_n_async,
  output logic             ready
);

  logic             rb_s1_q, rb_s2_q;
  logic [CNT_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1_q <= 1'b0;
      rb_s2_q <= 1'b0;
    end else begin
      rb_s1_q <= rb_n_async;
      rb_s2_q <= rb_s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (start) begin
      mask_q <= hold_len;
    end else if (mask_q != '0) begin
      mask_q <= mask_q - 1'b1;
    end
  end

  assign ready = rb_s2_q && (mask_q == '0);

  // R10
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hold_len != '0) |=> !ready);

endmodule

// File: rtl/nand_strobe_seq.sv
`timescale 1ns/1ps
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW_W-1:0]   timing_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rb_n,
  output logic              stat_nand_ready,
  output logic              stat_ctrl_idle
);

  seq_state_e        state_q, state_d;
  nand_op_e          op_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  strobe_cfg_t       cfg_q;
  timing_t           tw_in;
  logic              oe_q;
  logic              accept, active, is_read;
  logic              ph_load, ph_done, capture, busy_start;
  logic [PH_W-1:0]   ph_len;

  assign tw_in   = timing_t'(timing_word);
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign is_read = (op_q == OP_RDATA);

  function automatic logic [PH_W-1:0] low_len(input logic rd, input strobe_cfg_t c);
    return rd ? PH_W'(c.rd_low) : PH_W'(c.wr_low);
  endfunction

  function automatic logic [PH_W-1:0] high_len(input logic rd, input strobe_cfg_t c);
    return rd ? PH_W'(c.rd_high) : PH_W'(c.wr_high);
  endfunction

  // Phase sequencing: every transition reloads the shared phase timer.
  always_comb begin
    state_d    = state_q;
    ph_load    = 1'b0;
    ph_len     = '0;
    capture    = 1'b0;
    busy_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_CE;
          ph_load = 1'b1;
          ph_len  = PH_W'(tw_in.ce_dly);
        end
      end
      ST_CE: begin
        if (ph_done) begin
          ph_load = 1'b1;
          if (is_read && oe_q) begin
            state_d = ST_TURN;
            ph_len  = PH_W'(cfg_q.turn);
          end else begin
            state_d = ST_LOW;
            ph_len  = low_len(is_read, cfg_q);
          end
        end
      end
      ST_TURN: begin
        if (ph_done) begin
          state_d = ST_LOW;
          ph_load = 1'b1;
          ph_len  = low_len(1'b1, cfg_q);
        end
      end
      ST_LOW: begin
        if (ph_done) begin
          state_d = ST_HIGH;
          ph_load = 1'b1;
          ph_len  = high_len(is_read, cfg_q);
          capture = is_read;
        end
      end
      ST_HIGH: begin
        if (ph_done) begin
          state_d    = is_read ? ST_RESP : ST_IDLE;
          busy_start = (op_q == OP_CMD) || (op_q == OP_WDATA);
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_CMD;
      wdata_q <= '0;
      rdata_q <= '0;
      cfg_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q           <= nand_op_e'(req_op);
        wdata_q        <= req_data;
        cfg_q.busy_dly <= tw_in.busy_dly;
        cfg_q.turn     <= tw_in.turn;
        cfg_q.rd_high  <= tw_in.rd_high;
        cfg_q.rd_low   <= tw_in.rd_low;
        cfg_q.wr_high  <= tw_in.wr_high;
        cfg_q.wr_low   <= tw_in.wr_low;
      end
      if (capture) rdata_q <= nand_dq_i;
      // Writes park the bus driven; only a turnaround phase releases it.
      if (accept && nand_op_e'(req_op) != OP_RDATA) begin
        oe_q <= 1'b1;
      end else if (state_q == ST_CE && state_d == ST_TURN) begin
        oe_q <= 1'b0;
      end
    end
  end

  nand_phase_timer #(.CNT_W(PH_W)) u_phase_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_len (ph_len),
    .done     (ph_done)
  );

  nand_busy_guard #(.CNT_W(PH_W)) u_busy_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (busy_start),
    .hold_len   (cfg_q.busy_dly),
    .rb_n_async (nand_rb_n),
    .ready      (stat_nand_ready)
  );

  assign active         = (state_q == ST_CE) || (state_q == ST_TURN) ||
                          (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign nand_ce_n      = !active;
  assign nand_cle       = active && (op_q == OP_CMD);
  assign nand_ale       = active && (op_q == OP_ADDR);
  assign nand_we_n      = !((state_q == ST_LOW) && !is_read);
  assign nand_re_n      = !((state_q == ST_LOW) && is_read);
  assign nand_dq_o      = wdata_q;
  assign nand_dq_oe     = oe_q;
  assign req_ready      = (state_q == ST_IDLE);
  assign stat_ctrl_idle = (state_q == ST_IDLE);
  assign rsp_valid      = (state_q == ST_RESP);
  assign rsp_data       = rdata_q;

  // R9
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R2
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R12
  ce_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) || $fell(nand_re_n)) |-> $past(!nand_ce_n));

endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
module test_nand_strobe_seq;
  import nand_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] timing_word = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [7:0]  req_data = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i = '0;
  logic        nand_rb_n = 1'b1;
  logic        stat_nand_ready, stat_ctrl_idle;

  always #10 clk = ~clk;

  nand_strobe_seq #(.DATA_W(8)) i_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n),
    .stat_nand_ready(stat_nand_ready), .stat_ctrl_idle(stat_ctrl_idle)
  );

  typedef struct packed { logic [1:0] op; logic [7:0] data; logic [7:0] len; } obs_t;
  obs_t exp_q[$];

  int checks = 0, errors = 0, cyc = 0;
  bit park = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [25:0] mk(input int ce, input int busy, input int ta,
      input int rh, input int rl, input int wh, input int wl);
    return {ce[1:0], busy[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
  endfunction

  // Watchdog: a hang is a failed check and still reaches the summary.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Monitor: rebuild each strobe from the pins and compare with the queue.
  int wcnt = 0, rcnt = 0, rlen = 0;
  logic [1:0] wop;
  logic [7:0] wbyte;
  logic       woe;

  task automatic score(input obs_t got);
    obs_t e;
    string rq;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", "unexpected strobe op", got.op, 0);
      return;
    end
    e = exp_q.pop_front();
    rq = (e.op == 2'd0) ? "R3" : (e.op == 2'd1) ? "R4" : (e.op == 2'd2) ? "R5" : "R8";
    check(got.op == e.op, rq, "strobe kind", got.op, e.op);
    check(got.data == e.data, rq, "byte", got.data, e.data);
    check(got.len == e.len, "R6", "strobe low length", got.len, e.len);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) begin
        if (wcnt == 0) begin
          wop   = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
          wbyte = nand_dq_o;
          woe   = nand_dq_oe;
          if (nand_cle && nand_ale) wop = 2'd3;
        end
        wcnt++;
      end else if (wcnt != 0) begin
        check(woe == 1'b1, "R5", "bus driven during write", woe, 1);
        score({wop, wbyte, 8'(wcnt)});
        wcnt = 0;
      end
      if (!nand_re_n) rcnt++;
      else if (rcnt != 0) begin
        rlen = rcnt;
        rcnt = 0;
      end
      if (rsp_valid && rsp_ready) score({2'd3, rsp_data, 8'(rlen)});
    end
  end

  // Driver: one operation, with pushed scoreboard item and timing checks.
  task automatic do_op(input logic [1:0] op, input logic [7:0] b, input logic [7:0] dev);
    int tc, lo, total, n, m, bd;
    bit rd;
    rd = (op == 2'd3);
    tc = mx1(int'(timing_word[25:24]));
    bd = int'(timing_word[23:19]);
    lo = rd ? mx1(int'(timing_word[11:8])) : mx1(int'(timing_word[3:0]));
    if (rd)
      total = tc + (park ? mx1(int'(timing_word[18:16])) : 0) + lo +
              mx1(int'(timing_word[15:12])) + 1;
    else
      total = tc + lo + mx1(int'(timing_word[7:4]));
    exp_q.push_back({op, rd ? dev : b, 8'(lo)});
    nand_dq_i = dev;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = b;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    check(!nand_ce_n && nand_we_n && nand_re_n, "R12", "ce low, strobes idle after accept",
          {nand_ce_n, nand_we_n, nand_re_n}, 3'b011);
    check(!stat_ctrl_idle, "R2", "not idle while running", stat_ctrl_idle, 0);
    while (!req_ready && n < 300) begin @(negedge clk); n++; end
    check(n == total + 1, (rd && park) ? "R9" : (rd ? "R8" : "R6"), "busy clocks + 1", n, total + 1);
    check(nand_ce_n == 1'b1, "R12", "ce released", nand_ce_n, 1);
    check(nand_dq_oe == !rd, "R9", "bus park after op", nand_dq_oe, !rd);
    if (op == 2'd0 || op == 2'd2) begin
      m = 0;
      while (!stat_nand_ready && m < 100) begin @(negedge clk); m++; end
      check(m == bd, "R10", "busy mask clocks", m, bd);
    end else begin
      check(stat_nand_ready == 1'b1, "R10", "no busy mask", stat_nand_ready, 1);
    end
    park = !rd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
          "R1", "pins in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
          6'b111000);
    check(req_ready && stat_ctrl_idle && !rsp_valid, "R1", "handshake in reset",
          {req_ready, stat_ctrl_idle, rsp_valid}, 3'b110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(stat_nand_ready == 1'b1, "R11", "ready follows rb_n", stat_nand_ready, 1);

    // Mixed word.
    timing_word = mk(1, 3, 2, 2, 3, 1, 2);
    do_op(2'd0, 8'hFF, 8'h00);
    do_op(2'd1, 8'h12, 8'h00);
    do_op(2'd2, 8'hA5, 8'h00);
    do_op(2'd3, 8'h00, 8'h3C);
    do_op(2'd3, 8'h00, 8'hE1);

    // All-zero word: every phase one clock, no busy mask.
    timing_word = '0;
    do_op(2'd0, 8'h70, 8'h00);
    do_op(2'd3, 8'h00, 8'h81);

    // Maximum word.
    timing_word = mk(3, 31, 7, 15, 15, 15, 15);
    do_op(2'd2, 8'h5A, 8'h00);
    do_op(2'd3, 8'h00, 8'h96);

    // Back-pressure on the read response with a second request held off.
    timing_word = mk(2, 4, 1, 1, 2, 2, 1);
    @(posedge clk); #2 rsp_ready = 1'b0;
    @(negedge clk);
    exp_q.push_back({2'd3, 8'hC3, 8'd2});
    exp_q.push_back({2'd0, 8'h90, 8'd1});
    nand_dq_i = 8'hC3;
    req_valid = 1'b1; req_op = 2'd3; req_data = 8'h00;
    @(negedge clk);
    req_op = 2'd0; req_data = 8'h90;
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(rsp_valid && rsp_data == 8'hC3, "R8", "response held", rsp_data, 8'hC3);
      check(!req_ready && !nand_cle && nand_we_n, "R2", "pending request held off",
            {req_ready, nand_cle, nand_we_n}, 3'b001);
      @(negedge clk);
    end
    @(posedge clk); #2 rsp_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    while (!stat_nand_ready) @(negedge clk);
    park = 1'b1;

    // Ready/busy pin through the synchronizer.
    nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    check(stat_nand_ready == 1'b0, "R11", "busy pin seen", stat_nand_ready, 0);
    nand_rb_n = 1'b1;
    @(negedge clk);
    check(stat_nand_ready == 1'b0, "R11", "one stage in flight", stat_nand_ready, 0);
    @(negedge clk);
    check(stat_nand_ready == 1'b1, "R11", "ready after two stages", stat_nand_ready, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all expected strobes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule